// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware entry sequence that an 8-bit processor core runs when it takes an interrupt. The core presents its current program counter, stack pointer, interrupt page register, interrupt mode, enable flip-flops, halted flag and the flag that marks the instruction after an enable-interrupts instruction. It also presents a level-sensitive maskable request with its vector byte and a pulsed non-maskable request. The sequencer decides whether to accept the request. It saves the return address on the stack through a single-port synchronous memory. In table mode it fetches the handler address from a two-byte table entry. It then returns the new program counter, stack pointer and enable flip-flops with a one-cycle done pulse.

When the core sees the done pulse, it loads the returned values and clears its halted and EI-pending flags. Everything the sequencer needs is captured at the clock edge that accepts a request, so the core's inputs may change while the sequence runs. Instruction fetch and decode are outside this block.

Top module: `irq_entry_seq`

## Requirements
- R1: An idle sequencer accepts a non-maskable request whatever the enable flags hold. It accepts a maskable request (`int_req` high) only when the maskable enable holds. If both are present in the same cycle, the non-maskable request wins.
- R2: When `halted_in` is high at acceptance, the return address saved on the stack is `pc_in + 1`. Otherwise it is `pc_in`.
- R3: In the first cycle after the accepting edge, the return address high byte is written at `sp_in - 1`. In the next cycle, the low byte is written at `sp_in - 2`. The returned `sp_out` is `sp_in - 2`, and a write strobe and a read strobe are never high together.
- R4: A non-maskable entry returns `pc_out = 0x0066`, `iff1_out = 0`, and `iff2_out` equal to `iff2_in`. The mode is ignored.
- R5: A maskable entry returns `iff1_out = 0` and `iff2_out = 0`.
- R6: In mode 2 (`mode_in = 2'd2`), the sequencer reads the byte at address `{page_in, int_vec}` and then the byte at that address plus one, with a 16-bit carry across the page. The first byte is the low byte of `pc_out` and the second is the high byte. Read data arrives in the cycle after the read strobe.
- R7: In mode 1 (`mode_in = 2'd1`, and also `2'd3`), a maskable entry returns `pc_out = 0x0038` whatever the vector.
- R8: In mode 0 (`mode_in = 2'd0`), a maskable entry returns `pc_out = 8 * int_vec[5:3]`, which gives 0x0000 to 0x0038 in steps of 8.
- R9: While `ei_pend_in` is high, a maskable request is held off. It is accepted only in a cycle where `instr_end` is also high, which means the one following instruction has completed.
- R10: `done` is a single-cycle pulse with `busy` low. It rises 4 cycles after the request is driven for entries without a table read and 6 cycles after for table entries. The result outputs change only at that point and then hold.
- R11: `busy` stays high from the accepting edge until the sequence ends. A non-maskable request pulsed while busy is kept and serviced right after the done pulse. Input changes during a sequence do not affect that sequence's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request pulse |
| int_req | input | 1 | Maskable request level |
| int_vec | input | 8 | Vector byte supplied with the maskable request |
| instr_end | input | 1 | Current instruction has completed |
| pc_in | input | 16 | Core program counter |
| sp_in | input | 16 | Core stack pointer |
| page_in | input | 8 | Interrupt page register |
| mode_in | input | 2 | Interrupt mode 0, 1 or 2 |
| iff1_in | input | 1 | Enable flip-flop 1 |
| iff2_in | input | 1 | Enable flip-flop 2 |
| halted_in | input | 1 | Core is halted |
| ei_pend_in | input | 1 | Previous instruction enabled interrupts |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Results valid pulse |
| pc_out | output | 16 | Handler address |
| sp_out | output | 16 | Stack pointer after the push |
| iff1_out | output | 1 | New enable flip-flop 1 |
| iff2_out | output | 1 | New enable flip-flop 2 |

## Verification
The bound checker watches the memory port on every cycle. It checks that the first write after acceptance targets the stack pointer minus one and that the next write goes one address lower. It also checks that a table read is followed by a read of the next address, that reads and writes never overlap, and that every done pulse lasts one cycle, arrives while idle and carries a cleared enable flip-flop 1. The bench scenarios cover what depends on the values involved: the saved bytes, including the halt increment; the handler address in each mode, including a table entry that crosses a page; gating by the enable flags and by the EI-pending window; retention of iff2 on a non-maskable entry; latency; and a non-maskable request arriving during a running sequence.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_HI = 3'd1,
    ST_PUSH_LO = 3'd2,
    ST_TBL_LO  = 3'd3,
    ST_TBL_HI  = 3'd4,
    ST_FINISH  = 3'd5
  } seq_state_e;

  localparam logic [1:0] MODE_RESTART = 2'd0;
  localparam logic [1:0] MODE_FIXED   = 2'd1;
  localparam logic [1:0] MODE_TABLE   = 2'd2;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic nmi_req,
  input  logic int_req,
  input  logic iff1_in,
  input  logic ei_pend_in,
  input  logic instr_end,
  output logic take_nmi,
  output logic take_int
);

  logic nmi_pend_q;
  logic nmi_pend_d;
  logic nmi_any;
  logic int_en;

  always_comb begin
    nmi_any    = nmi_req | nmi_pend_q;
    int_en     = ei_pend_in ? instr_end : iff1_in;
    take_nmi   = idle & nmi_any;
    take_int   = idle & ~nmi_any & int_req & int_en;
    nmi_pend_d = nmi_any & ~take_nmi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_pend_q <= 1'b0;
    else        nmi_pend_q <= nmi_pend_d;
  end

endmodule

// File: rtl/irq_target.sv
module irq_target #(
  parameter int DW        = 8,
  parameter int AW        = 2 * DW,
  parameter int RST_SHIFT = 3,
  parameter logic [AW-1:0] NMI_PC   = 16'h0066,
  parameter logic [AW-1:0] FIXED_PC = 16'h0038
) (
  input  logic          is_nmi,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] vec,
  input  logic [DW-1:0] tbl_lo,
  input  logic [DW-1:0] tbl_hi,
  output logic [AW-1:0] target
);
  import irq_entry_pkg::*;

  localparam int IDX_W = 3;

  logic [IDX_W-1:0] rst_idx;
  logic [AW-1:0]    rst_pc;

  always_comb begin
    rst_idx = vec[RST_SHIFT +: IDX_W];
    rst_pc  = {{(AW-IDX_W){1'b0}}, rst_idx} << RST_SHIFT;
    if (is_nmi) begin
      target = NMI_PC;
    end else begin
      unique case (mode)
        MODE_RESTART: target = rst_pc;
        MODE_TABLE:   target = {tbl_hi, tbl_lo};
        default:      target = FIXED_PC;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_req,
  input  logic          int_req,
  input  logic [DW-1:0] int_vec,
  input  logic          instr_end,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] page_in,
  input  logic [1:0]    mode_in,
  input  logic          iff1_in,
  input  logic          iff2_in,
  input  logic          halted_in,
  input  logic          ei_pend_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] sp_out,
  output logic          iff1_out,
  output logic          iff2_out
);
  import irq_entry_pkg::*;

  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  seq_state_e state_q, state_d;
  logic       take_nmi, take_int, accept, use_table, finish_en;

  // snapshot taken at the accepting edge
  logic          nmi_q, iff2_q;
  logic [1:0]    mode_q;
  logic [DW-1:0] vec_q, page_q, tlo_q;
  logic [AW-1:0] ret_pc_q, sp_q;
  logic [AW-1:0] target;

  // result registers
  logic [AW-1:0] pc_out_q, sp_out_q;
  logic          iff1_out_q, iff2_out_q, done_q;

  irq_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (state_q == ST_IDLE),
    .nmi_req    (nmi_req),
    .int_req    (int_req),
    .iff1_in    (iff1_in),
    .ei_pend_in (ei_pend_in),
    .instr_end  (instr_end),
    .take_nmi   (take_nmi),
    .take_int   (take_int)
  );

  irq_target #(.DW(DW), .AW(AW)) u_tgt (
    .is_nmi (nmi_q),
    .mode   (mode_q),
    .vec    (vec_q),
    .tbl_lo (tlo_q),
    .tbl_hi (mem_rdata),
    .target (target)
  );

  always_comb begin
    accept    = take_nmi | take_int;
    use_table = ~nmi_q & (mode_q == MODE_TABLE);
    finish_en = (state_q == ST_FINISH);
    state_d   = state_q;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_PUSH_HI;
      ST_PUSH_HI: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - ONE;
        mem_wdata = ret_pc_q[AW-1:DW];
        state_d   = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - TWO;
        mem_wdata = ret_pc_q[DW-1:0];
        state_d   = use_table ? ST_TBL_LO : ST_FINISH;
      end
      ST_TBL_LO: begin
        mem_re   = 1'b1;
        mem_addr = {page_q, vec_q};
        state_d  = ST_TBL_HI;
      end
      ST_TBL_HI: begin
        mem_re   = 1'b1;
        mem_addr = {page_q, vec_q} + ONE;
        state_d  = ST_FINISH;
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      iff2_q   <= 1'b0;
      mode_q   <= '0;
      vec_q    <= '0;
      page_q   <= '0;
      ret_pc_q <= '0;
      sp_q     <= '0;
    end else if (accept) begin
      nmi_q    <= take_nmi;
      iff2_q   <= iff2_in;
      mode_q   <= mode_in;
      vec_q    <= int_vec;
      page_q   <= page_in;
      ret_pc_q <= halted_in ? pc_in + ONE : pc_in;
      sp_q     <= sp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tlo_q <= '0;
    else if (state_q == ST_TBL_HI) tlo_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out_q   <= '0;
      sp_out_q   <= '0;
      iff1_out_q <= 1'b0;
      iff2_out_q <= 1'b0;
    end else if (finish_en) begin
      pc_out_q   <= target;
      sp_out_q   <= sp_q - TWO;
      iff1_out_q <= 1'b0;
      iff2_out_q <= nmi_q & iff2_q;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign pc_out   = pc_out_q;
  assign sp_out   = sp_out_q;
  assign iff1_out = iff1_out_q;
  assign iff2_out = iff2_out_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [15:0] sp_in,
  input logic        iff1_out
);

  // R3: first write after acceptance lands just below the stack pointer
  a_r3_push_hi_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_we && mem_addr == $past(sp_in) - 16'd1));

  // R3: second write follows at the next lower address
  a_r3_push_lo_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (mem_we && mem_addr == $past(mem_addr) - 16'd1));

  // R3: never read and write at once
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R6: table low read is followed by a read of the next address
  a_r6_table_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_re) |=> (mem_re && mem_addr == $past(mem_addr) + 16'd1));

  // R10: done lasts one cycle and comes while idle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4 / R5: every entry leaves enable flip-flop 1 cleared
  a_r5_iff1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !iff1_out);

endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .sp_in    (sp_in),
  .iff1_out (iff1_out)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_req, int_req, instr_end;
  logic [7:0]  int_vec, page_in, mem_wdata, mem_rdata;
  logic [15:0] pc_in, sp_in, mem_addr, pc_out, sp_out;
  logic [1:0]  mode_in;
  logic        iff1_in, iff2_in, halted_in, ei_pend_in;
  logic        mem_we, mem_re, busy, done, iff1_out, iff2_out;

  int n_checks = 0;
  int n_err    = 0;

  logic [7:0] mem [0:4095];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
  end

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .int_req(int_req),
    .int_vec(int_vec), .instr_end(instr_end), .pc_in(pc_in), .sp_in(sp_in),
    .page_in(page_in), .mode_in(mode_in), .iff1_in(iff1_in), .iff2_in(iff2_in),
    .halted_in(halted_in), .ei_pend_in(ei_pend_in), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_out(pc_out),
    .sp_out(sp_out), .iff1_out(iff1_out), .iff2_out(iff2_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [15:0] pc, input logic [15:0] sp, input logic [7:0] page,
                       input logic [7:0] vec, input logic [1:0] mode, input logic i1,
                       input logic i2, input logic hl, input logic ep);
    pc_in = pc; sp_in = sp; page_in = page; int_vec = vec; mode_in = mode;
    iff1_in = i1; iff2_in = i2; halted_in = hl; ei_pend_in = ep;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin nmi_req = 1'b0; int_req = 1'b0; instr_end = 1'b0; end
    end while (!done && lat < 30);
  endtask

  task automatic run_entry(input string req, input logic is_nmi, input logic [15:0] exp_pc,
                           input logic exp_iff2, input int exp_lat, input logic [15:0] ret_pc);
    int lat;
    logic [15:0] sp0;
    sp0 = sp_in;
    if (is_nmi) nmi_req = 1'b1; else int_req = 1'b1;
    wait_done(lat);
    check({req, " latency"}, lat, exp_lat);
    check({req, " pc_out"}, pc_out, exp_pc);
    check({req, " R3 sp_out"}, sp_out, sp0 - 16'd2);
    check({req, " iff1_out"}, iff1_out, 1'b0);
    check({req, " iff2_out"}, iff2_out, exp_iff2);
    check({req, " R3 stack hi"}, mem[(sp0 - 16'd1) & 16'h0FFF], ret_pc[15:8]);
    check({req, " R3 stack lo"}, mem[(sp0 - 16'd2) & 16'h0FFF], ret_pc[7:0]);
  endtask

  task automatic t_reset;
    check("R10 reset done", done, 1'b0);
    check("R11 reset busy", busy, 1'b0);
    check("R10 reset pc_out", pc_out, 16'h0000);
    check("R3 reset strobes", {mem_we, mem_re}, 2'b00);
  endtask

  task automatic t_nmi;
    setup(16'h1234, 16'hF000, 8'h00, 8'h55, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_entry("R4 nmi iff2 kept", 1'b1, 16'h0066, 1'b1, 4, 16'h1234);
    setup(16'h0A0B, 16'hF000, 8'h00, 8'h55, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_entry("R1 R4 nmi while disabled", 1'b1, 16'h0066, 1'b0, 4, 16'h0A0B);
    setup(16'h0C0D, 16'hF000, 8'h12, 8'h34, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    run_entry("R4 nmi ignores table mode", 1'b1, 16'h0066, 1'b1, 4, 16'h0C0D);
  endtask

  task automatic t_blocked;
    int seen;
    logic [15:0] prev;
    seen = 0;
    prev = pc_out;
    setup(16'h3333, 16'hF000, 8'h00, 8'h00, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    int_req = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy || done) seen++;
    end
    int_req = 1'b0;
    check("R1 masked request ignored", seen, 0);
    check("R1 pc_out unchanged", pc_out, prev);
  endtask

  task automatic t_fixed_halt;
    setup(16'h20FF, 16'hF000, 8'h00, 8'hA5, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    run_entry("R2 R5 R7 halted fixed", 1'b0, 16'h0038, 1'b0, 4, 16'h2100);
    setup(16'h4444, 16'hF000, 8'h00, 8'h00, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    run_entry("R7 mode3 fixed", 1'b0, 16'h0038, 1'b0, 4, 16'h4444);
  endtask

  task automatic t_restart;
    setup(16'h5566, 16'hF000, 8'h00, 8'hEF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_entry("R8 restart 28", 1'b0, 16'h0028, 1'b0, 4, 16'h5566);
    setup(16'h5567, 16'hF000, 8'h00, 8'hC7, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_entry("R8 restart 00", 1'b0, 16'h0000, 1'b0, 4, 16'h5567);
    setup(16'h5568, 16'hF000, 8'h00, 8'hFF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_entry("R8 restart 38", 1'b0, 16'h0038, 1'b0, 4, 16'h5568);
  endtask

  task automatic t_table;
    mem[12'h234] = 8'hCD; mem[12'h235] = 8'hAB;
    mem[12'h2FF] = 8'h11; mem[12'h300] = 8'h22;
    setup(16'h7788, 16'hF000, 8'h12, 8'h34, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    run_entry("R6 table lookup", 1'b0, 16'hABCD, 1'b0, 6, 16'h7788);
    setup(16'h7789, 16'hF000, 8'h12, 8'hFF, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);
    run_entry("R6 R2 table page carry", 1'b0, 16'h2211, 1'b0, 6, 16'h778A);
  endtask

  task automatic t_ei_window;
    int seen;
    seen = 0;
    setup(16'h6000, 16'hF000, 8'h00, 8'h00, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1);
    int_req = 1'b1;
    instr_end = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    check("R9 held off during EI window", seen, 0);
    instr_end = 1'b1;
    run_entry("R9 accepted after instruction", 1'b0, 16'h0038, 1'b0, 4, 16'h6000);
  endtask

  task automatic t_priority;
    setup(16'h1111, 16'hF000, 8'h00, 8'h00, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    int_req = 1'b1;
    run_entry("R1 nmi wins", 1'b1, 16'h0066, 1'b1, 4, 16'h1111);
    @(negedge clk);
    check("R1 loser not replayed", busy, 1'b0);
  endtask

  task automatic t_nmi_while_busy;
    int lat;
    setup(16'h4000, 16'hE800, 8'h00, 8'h00, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    int_req = 1'b1;
    @(negedge clk);
    int_req = 1'b0;
    check("R11 busy after accept", busy, 1'b1);
    @(negedge clk);
    nmi_req = 1'b1; sp_in = 16'hE000; pc_in = 16'h5000;
    @(negedge clk);
    nmi_req = 1'b0;
    @(negedge clk);
    check("R11 first done", done, 1'b1);
    check("R11 first pc_out", pc_out, 16'h0038);
    check("R11 snapshot sp_out", sp_out, 16'hE7FE);
    check("R11 snapshot stack hi", mem[12'h7FF], 8'h40);
    wait_done(lat);
    check("R11 queued nmi latency", lat, 4);
    check("R11 queued nmi pc_out", pc_out, 16'h0066);
    check("R11 queued nmi sp_out", sp_out, 16'hDFFE);
    check("R11 queued nmi stack hi", mem[12'hFFF], 8'h50);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst_n = 1'b0; nmi_req = 1'b0; int_req = 1'b0; instr_end = 1'b0;
    setup(16'h0000, 16'hF000, 8'h00, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_nmi();
    t_blocked();
    t_fixed_halt();
    t_restart();
    t_table();
    t_ei_window();
    t_priority();
    t_nmi_while_busy();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule